// File: doc/BRIEF.md
# Zero-Filling Bitfield Move Unit

This execute-stage unit takes one 32-bit instruction word and one 64-bit source operand and returns the result of an unsigned bitfield move. It decodes a width flag, a rotate immediate, a size immediate and the destination register index from the instruction. It then does one of two things, depending on how the two immediates compare. It either pulls a field out of the source down to bit zero, or it lifts the low source bits up to a higher position. Every bit outside the moved field is cleared.

The result is registered, so it appears one cycle after the request. A flag marks a request whose encoding the unit rejects. Condition flags are neither read nor written, and register file access lies outside the unit.

Top module: `bfz_unit`

## Requirements
- R1: A request is legal only when all three of these hold. Instruction bits 30:23 equal 8'b10100110. Bit 31 (width flag, 1 = 64-bit) equals bit 22. When bit 31 is 0, bit 21 and bit 15 (the top bits of the two immediates) are both 0.
- R2: The rotate immediate `r` is bits 21:16, the size immediate `s` is bits 15:10, and the destination index is bits 4:0. `outDest` returns bits 4:0 of the accepted instruction. The base words are 0x53000000 for the 32-bit form and 0xD3400000 for the 64-bit form.
- R3: When s >= r, result bits [s-r:0] equal source bits [s:r], and all higher result bits are zero.
- R4: When s < r, result bits [W-r+s : W-r] equal source bits [s:0], where W is 32 or 64. All other result bits are zero.
- R5: In the 32-bit form only source bits 31:0 affect the result, and result bits 63:32 are zero.
- R6: In the 64-bit form all 64 source bits take part, including fields that reach bit 63.
- R7: A synchronous active-high reset clears `outValid` and `outIllegal` on the next edge.
- R8: A request with `inValid` high and an illegal encoding raises `outIllegal` and not `outValid`. `outResult` is zero whenever `outValid` is low.
- R9: Results appear exactly one cycle after the request. A cycle with `inValid` low leaves both flags low one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| inValid | input | 1 | Request present this cycle |
| instr | input | 32 | Instruction word |
| srcData | input | 64 | Source operand |
| outValid | output | 1 | Legal result available |
| outIllegal | output | 1 | Rejected encoding |
| outResult | output | 64 | Moved bitfield, zero filled |
| outDest | output | 5 | Destination register index |

## Verification
The assertions assume that reset is applied before the first request. They also assume that the instruction and the operand are stable across the edge that captures them. On that basis, they can relate a registered result to the decode of the previous cycle.

The bench meets these assumptions. It holds reset for several cycles, and it drives every input on the falling edge. It sweeps every immediate pair for both widths, which keeps legal requests within the range of widths and immediates allowed by R1. Illegal encodings are produced on purpose, one rule at a time, so that each rejection path is exercised on its own.

// File: rtl/bfz_pkg.sv
package bfz_pkg;
  localparam int DATA_W  = 64;
  localparam int HALF_W  = DATA_W / 2;
  localparam int INSTR_W = 32;
  localparam int IMM_W   = 6;
  localparam int REG_W   = 5;
  localparam int POS_W   = IMM_W + 1;
  localparam logic [7:0] FIXED_PAT = 8'b10100110;

  typedef struct packed {
    logic             is64;
    logic             extract;
    logic [IMM_W-1:0] rotAmt;
    logic [POS_W-1:0] fieldLen;
    logic [POS_W-1:0] placePos;
  } bfzCtl_t;
endpackage

// File: rtl/bfz_decode.sv
module bfz_decode
  import bfz_pkg::*;
(
  input  logic [INSTR_W-1:0] instr,
  output bfzCtl_t            ctl,
  output logic               legal,
  output logic [REG_W-1:0]   destIdx
);
  logic             sfBit, nBit;
  logic [IMM_W-1:0] immR, immS;
  logic [POS_W-1:0] regSize;

  always_comb begin
    sfBit   = instr[31];
    nBit    = instr[22];
    immR    = instr[21:16];
    immS    = instr[15:10];
    destIdx = instr[REG_W-1:0];
    legal   = (instr[30:23] == FIXED_PAT) && (sfBit == nBit) &&
              (sfBit || (!immR[IMM_W-1] && !immS[IMM_W-1]));
    regSize = sfBit ? POS_W'(DATA_W) : POS_W'(HALF_W);

    ctl.is64    = sfBit;
    ctl.extract = (immS >= immR);
    ctl.rotAmt  = immR;
    if (ctl.extract) begin
      ctl.fieldLen = {1'b0, immS} - {1'b0, immR} + POS_W'(1);
      ctl.placePos = '0;
    end else begin
      ctl.fieldLen = {1'b0, immS} + POS_W'(1);
      ctl.placePos = regSize - {1'b0, immR};
    end
  end
endmodule

// File: rtl/bfz_datapath.sv
module bfz_datapath
  import bfz_pkg::*;
(
  input  bfzCtl_t            ctl,
  input  logic [DATA_W-1:0]  srcData,
  output logic [DATA_W-1:0]  result
);
  logic [DATA_W-1:0] rotWide, rotSel, lowMask, fieldMask;
  logic [HALF_W-1:0] srcHalf, rotHalf;

  always_comb begin
    rotWide = (srcData >> ctl.rotAmt) |
              (srcData << (POS_W'(DATA_W) - {1'b0, ctl.rotAmt}));
    srcHalf = srcData[HALF_W-1:0];
    rotHalf = (srcHalf >> ctl.rotAmt[IMM_W-2:0]) |
              (srcHalf << (IMM_W'(HALF_W) - {1'b0, ctl.rotAmt[IMM_W-2:0]}));
    rotSel    = ctl.is64 ? rotWide : {{HALF_W{1'b0}}, rotHalf};
    lowMask   = ~({DATA_W{1'b1}} << ctl.fieldLen);
    fieldMask = lowMask << ctl.placePos;
    result    = rotSel & fieldMask;
  end
endmodule

// File: rtl/bfz_unit.sv
module bfz_unit
  import bfz_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic               inValid,
  input  logic [31:0]        instr,
  input  logic [63:0]        srcData,
  output logic               outValid,
  output logic               outIllegal,
  output logic [63:0]        outResult,
  output logic [4:0]         outDest
);
  bfzCtl_t            ctl;
  logic               legal;
  logic [REG_W-1:0]   destIdx;
  logic [DATA_W-1:0]  result;

  bfz_decode u_dec (.instr(instr), .ctl(ctl), .legal(legal), .destIdx(destIdx));
  bfz_datapath u_dp (.ctl(ctl), .srcData(srcData), .result(result));

  always_ff @(posedge clk) begin
    if (rst) begin
      outValid   <= 1'b0;
      outIllegal <= 1'b0;
      outResult  <= '0;
      outDest    <= '0;
    end else begin
      outValid   <= inValid && legal;
      outIllegal <= inValid && !legal;
      outResult  <= (inValid && legal) ? result : '0;
      outDest    <= destIdx;
    end
  end

  // R7: reset clears both flags on the next edge
  a_r7_reset_clears: assert property (@(posedge clk)
    rst |=> (!outValid && !outIllegal));

  // R8: the two flags never rise together, and the result is zero without outValid
  a_r8_flags_exclusive: assert property (@(posedge clk) disable iff (rst)
    !(outValid && outIllegal));
  a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
    !outValid |-> (outResult == '0));

  // R9: a missing request gives quiet flags one cycle later
  a_r9_no_req_quiet: assert property (@(posedge clk) disable iff (rst)
    !inValid |=> (!outValid && !outIllegal));
  a_r9_req_answered: assert property (@(posedge clk) disable iff (rst)
    inValid |=> (outValid || outIllegal));

  // R5: 32-bit results leave the upper half clear
  a_r5_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (inValid && !ctl.is64) |=> (outResult[63:32] == '0));

  // R3: an extracted field leaves nothing above its length
  a_r3_extract_top_clear: assert property (@(posedge clk) disable iff (rst)
    (inValid && legal && ctl.extract) |=> ((outResult >> $past(ctl.fieldLen)) == '0));

  // R4: a deposited field leaves nothing below its position
  a_r4_deposit_low_clear: assert property (@(posedge clk) disable iff (rst)
    (inValid && legal && !ctl.extract) |=>
      ((outResult << (POS_W'(DATA_W) - $past(ctl.placePos))) == '0));
endmodule

// File: tb/sim_bfz_unit.sv
module sim_bfz_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        inValid = 1'b0;
  logic [31:0] instr = '0;
  logic [63:0] srcData = '0;
  logic        outValid, outIllegal;
  logic [63:0] outResult;
  logic [4:0]  outDest;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  bfz_unit u0 (.clk(clk), .rst(rst), .inValid(inValid), .instr(instr),
               .srcData(srcData), .outValid(outValid), .outIllegal(outIllegal),
               .outResult(outResult), .outDest(outDest));

  function automatic logic [63:0] refModel(bit w64, int r, int s, logic [63:0] src);
    int w = w64 ? 64 : 32;
    logic [63:0] x = w64 ? src : {32'b0, src[31:0]};
    logic [63:0] rot, m;
    rot = (x >> r) | (x << (w - r));
    if (!w64) rot[63:32] = '0;
    if (s >= r) m = (s - r + 1 == 64) ? '1 : ((64'd1 << (s - r + 1)) - 1);
    else        m = ((64'd1 << (s + 1)) - 1) << (w - r);
    return rot & m;
  endfunction

  function automatic logic [31:0] mkInstr(bit w64, int r, int s, int rd);
    logic [31:0] base = w64 ? 32'hD3400000 : 32'h53000000;
    return base | (32'(r) << 16) | (32'(s) << 10) | (32'(7) << 5) | 32'(rd);
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic issue(bit v, logic [31:0] ins, logic [63:0] src);
    @(negedge clk);
    inValid = v; instr = ins; srcData = src;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  task automatic legalCase(string req, bit w64, int r, int s, logic [63:0] src);
    int rd = (r + s) % 32;
    issue(1'b1, mkInstr(w64, r, s, rd), src);
    check(req, {62'b0, outValid, outIllegal}, 64'b10);
    check(req, outResult, refModel(w64, r, s, src));
    check("R2", {59'b0, outDest}, 64'(rd));
  endtask

  task automatic illegalCase(string req, logic [31:0] ins);
    issue(1'b1, ins, 64'hFFFF_FFFF_FFFF_FFFF);
    check(req, {62'b0, outValid, outIllegal}, 64'b01);
    check("R8", outResult, 64'b0);
  endtask

  initial begin
    logic [63:0] d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    check("R7", {62'b0, outValid, outIllegal}, 64'b0);
    rst = 1'b0;

    // R3 R4 R6 directed corners, 64-bit
    legalCase("R3", 1'b1, 0, 63, 64'h8123_4567_89AB_CDEF);
    legalCase("R3", 1'b1, 17, 17, 64'h0000_0000_0002_0000);
    legalCase("R4", 1'b1, 1, 0, 64'h0000_0000_0000_0001);
    legalCase("R6", 1'b1, 63, 63, 64'h8000_0000_0000_0000);
    // R5: upper source bits have no effect, upper result zero
    legalCase("R5", 1'b0, 0, 31, 64'hFFFF_FFFF_1234_5678);
    legalCase("R5", 1'b0, 1, 0, 64'hFFFF_FFFF_FFFF_FFFF);
    legalCase("R5", 1'b0, 9, 9, 64'hAAAA_AAAA_0000_0200);

    // full sweeps with random data
    for (int r = 0; r < 64; r++)
      for (int s = 0; s < 64; s++) begin
        d = {$urandom, $urandom};
        legalCase(s >= r ? "R3" : "R4", 1'b1, r, s, d);
      end
    for (int r = 0; r < 32; r++)
      for (int s = 0; s < 32; s++) begin
        d = {$urandom, $urandom};
        legalCase("R5", 1'b0, r, s, d);
      end

    // R1 rejection rules
    illegalCase("R1", 32'h53000000 | 32'h0040_0000);
    illegalCase("R1", 32'hD3400000 & ~32'h0040_0000);
    illegalCase("R1", mkInstr(1'b0, 32, 0, 1));
    illegalCase("R1", mkInstr(1'b0, 0, 32, 1));
    illegalCase("R1", 32'h73000000);
    illegalCase("R1", 32'h52000000);

    // R9: no request gives quiet outputs
    issue(1'b0, mkInstr(1'b1, 3, 10, 2), 64'hFFFF);
    check("R9", {62'b0, outValid, outIllegal}, 64'b0);
    check("R8", outResult, 64'b0);

    // R7: reset after a valid result
    @(negedge clk);
    inValid = 1'b1; instr = mkInstr(1'b1, 0, 7, 3); srcData = 64'hFF;
    rst = 1'b1;
    @(negedge clk);
    check("R7", {62'b0, outValid, outIllegal}, 64'b0);
    rst = 1'b0; inValid = 1'b0;
    done = 1'b1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog actual=hung expected=done");
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule